// File: doc/BRIEF.md
# Double-Rate Data/Strobe Bit Decoder

This block turns a data/strobe encoded serial line pair into decoded bits. Both lines are sampled on the rising and on the falling edge of a fast receive clock. In each receive-clock cycle the decoder therefore looks at two consecutive sample pairs. Each pair counts as a new bit only when the XOR of data and strobe has changed since the pair before it. The block reports zero, one or two bits per cycle through a two-bit valid mask. It also keeps a free-running three-bit activity counter. A consumer in another clock domain can watch this counter to see whether the line is alive.

A single `enable` input controls the whole block. It clears the synchronizer flops and the control state machine at once. The enable is then brought into the receive domain through a synchronizer chain. The state machine has two states:
- `RX_HOLD`: decoding is suppressed and the valid mask, the XOR reference and the activity counter are held at zero.
- `RX_RUN`: decoding is active.

There are two transitions:
- **arm** (`RX_HOLD` to `RX_RUN`): taken when the synchronized enable is high.
- **drop** (`RX_RUN` to `RX_HOLD`): taken when the synchronized enable is low, or at once when `enable` goes low.

Top module: `ds_dual_rate_decoder`

## Requirements
- R1: Both lines are sampled on the falling edge and on the rising edge of `rx_clk`. For a falling-edge sample followed by the next rising-edge sample, the falling sample is the first (earlier) pair of the cycle and the rising sample is the second.
- R2: A sample pair is a new bit exactly when its data XOR strobe differs from the XOR of the sample pair taken just before it.
- R3: `bit_vld` is 2'b00 for no bit, 2'b01 for one bit (held in `bit_out[0]`) and 2'b11 for two bits (`bit_out[0]` first, `bit_out[1]` second). The value 2'b10 never appears.
- R4: When only the second pair of a cycle is a new bit, its data value appears in `bit_out[0]`. When both pairs are new bits, `bit_out[0]` carries the first pair's data and `bit_out[1]` the second pair's data.
- R5: The XOR of the second pair of each cycle is kept as the reference for the first pair of the next cycle. Transitions across cycle boundaries are therefore detected.
- R6: `act_cnt` increments by one, modulo 8, in the same cycle as any nonzero `bit_vld`.
- R7: `act_cnt` holds its value in every running cycle whose `bit_vld` is 2'b00.
- R8: While `enable` is low, `bit_vld` is 2'b00 and `act_cnt` is 0 from the next rising edge on, whatever the lines do. The XOR reference is cleared to 0 at the same time.
- R9: The block stays in `RX_HOLD` and keeps its outputs cleared until the enable has passed two synchronizer stages and the state register. If `enable` rises between rising edges k and k+1, the first decoded result appears at edge k+4.
- R10: Pairs sampled on a falling edge and on the following rising edge k are reported at the outputs from rising edge k+2 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Fast receive clock; both edges sample the line |
| enable | input | 1 | Active-high run control; low clears the block |
| din | input | 1 | Serial data line |
| sin | input | 1 | Serial strobe line |
| bit_out | output | 2 | Decoded bits; position 0 is the earlier bit |
| bit_vld | output | 2 | Valid mask for `bit_out` (00, 01, 11) |
| act_cnt | output | 3 | Activity counter, advances on each cycle with bits |

## Verification
The properties assume several things about the inputs:
- In every half cycle at most one of `din` and `sin` changes.
- Both lines are steady around each sampling edge of either polarity.
- `enable` is only moved between clock edges.

The bench keeps within these rules. It drives each half-bit a quarter period after an edge. Every new bit it creates flips exactly one line, so the XOR toggles. It moves `enable` only in that same quarter-period slot. Random traffic mixes held half-cycles with new bits, and directed phases cover three further cases:
- single bits on either edge;
- full-rate pairs;
- traffic that keeps running across both enable transitions.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic {
        RX_HOLD = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic d;
        logic s;
    } ds_pair_t;

endpackage

// File: rtl/dsd_edge_capture.sv
module dsd_edge_capture
    import dsd_pkg::*;
(
    input  logic     clk,
    input  ds_pair_t line_i,
    output ds_pair_t early_o,
    output ds_pair_t late_o
);
    ds_pair_t fall_raw;
    ds_pair_t fall_fab;
    ds_pair_t rise_raw;
    ds_pair_t early_q;
    ds_pair_t late_q;

    // falling-edge capture, then a second fabric stage on the same edge
    always_ff @(negedge clk) begin
        fall_raw <= line_i;
        fall_fab <= fall_raw;
    end

    // rising-edge capture and realignment of both pairs
    always_ff @(posedge clk) begin
        rise_raw <= line_i;
        early_q  <= fall_fab;
        late_q   <= rise_raw;
    end

    assign early_o = early_q;
    assign late_o  = late_q;
endmodule

// File: rtl/dsd_enable_ctrl.sv
module dsd_enable_ctrl
    import dsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      en_i,
    output logic      hold_o,
    output rx_state_e state_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    rx_state_e     state_q;
    rx_state_e     state_d;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge en_i) begin
                if (!en_i) sync_q <= '0;
                else       sync_q <= {sync_q[LAST-1:0], 1'b1};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge en_i) begin
                if (!en_i) sync_q <= '0;
                else       sync_q <= 1'b1;
            end
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge en_i) begin
        if (!en_i) state_q <= RX_HOLD;
        else       state_q <= state_d;
    end

    // transitions: arm (HOLD->RUN), drop (RUN->HOLD)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HOLD: if (sync_q[LAST])  state_d = RX_RUN;
            RX_RUN:  if (!sync_q[LAST]) state_d = RX_HOLD;
            default: state_d = RX_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        hold_o = 1'b1;
        unique case (state_q)
            RX_HOLD: hold_o = 1'b1;
            RX_RUN:  hold_o = 1'b0;
            default: hold_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dsd_bit_extract.sv
module dsd_bit_extract
    import dsd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             hold_i,
    input  ds_pair_t         early_i,
    input  ds_pair_t         late_i,
    output logic [1:0]       bits_o,
    output logic [1:0]       vld_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic             ref_x;
    logic             x_early;
    logic             x_late;
    logic             edge_early;
    logic             edge_late;
    logic [1:0]       bits_q;
    logic [1:0]       vld_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        x_early    = early_i.d ^ early_i.s;
        x_late     = late_i.d ^ late_i.s;
        edge_early = x_early ^ ref_x;
        edge_late  = x_late ^ x_early;
    end

    always_ff @(posedge clk) begin
        bits_q[0] <= edge_early ? early_i.d : late_i.d;
        bits_q[1] <= late_i.d;
        if (hold_i) begin
            vld_q <= 2'b00;
            ref_x <= 1'b0;
            cnt_q <= '0;
        end else begin
            vld_q <= {edge_early & edge_late, edge_early | edge_late};
            ref_x <= x_late;
            if (edge_early | edge_late) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bits_o = bits_q;
    assign vld_o  = vld_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/ds_dual_rate_decoder.sv
module ds_dual_rate_decoder
    import dsd_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             rx_clk,
    input  logic             enable,
    input  logic             din,
    input  logic             sin,
    output logic [1:0]       bit_out,
    output logic [1:0]       bit_vld,
    output logic [CNT_W-1:0] act_cnt
);
    ds_pair_t  line;
    ds_pair_t  early;
    ds_pair_t  late;
    logic      hold;
    rx_state_e state;

    assign line = '{d: din, s: sin};

    dsd_edge_capture u_cap (
        .clk     (rx_clk),
        .line_i  (line),
        .early_o (early),
        .late_o  (late)
    );

    dsd_enable_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk     (rx_clk),
        .en_i    (enable),
        .hold_o  (hold),
        .state_o (state)
    );

    dsd_bit_extract #(.CNT_W(CNT_W)) u_ext (
        .clk     (rx_clk),
        .hold_i  (hold),
        .early_i (early),
        .late_i  (late),
        .bits_o  (bit_out),
        .vld_o   (bit_vld),
        .cnt_o   (act_cnt)
    );
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             en,
    input logic             hold,
    input logic [1:0]       vld,
    input logic [CNT_W-1:0] cnt
);
    // R8
    hold_clears_chk: assert property (@(posedge clk) disable iff (!en)
        hold |=> (vld == 2'b00 && cnt == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (hold)
        (vld[0] && !$past(hold)) |-> cnt == CNT_W'($past(cnt) + 1'b1));

    // R7
    cnt_still_chk: assert property (@(posedge clk) disable iff (hold)
        (!vld[0] && !$past(hold)) |-> $stable(cnt));

    // R9
    run_entry_chk: assert property (@(posedge clk) disable iff (!en)
        $fell(hold) |-> ($past(en, 2) && $past(en, 3)));
endmodule

bind ds_dual_rate_decoder dsd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk  (rx_clk),
    .en   (enable),
    .hold (hold),
    .vld  (bit_vld),
    .cnt  (act_cnt)
);

// File: tb/tb_ds_dual_rate_decoder.sv
module tb_ds_dual_rate_decoder;
    localparam int NSTEP = 1400;

    logic       rx_clk = 1'b0;
    logic       enable = 1'b0;
    logic       din = 1'b0;
    logic       sin = 1'b0;
    logic [1:0] bit_out;
    logic [1:0] bit_vld;
    logic [2:0] act_cnt;

    ds_dual_rate_decoder dut (
        .rx_clk  (rx_clk),
        .enable  (enable),
        .din     (din),
        .sin     (sin),
        .bit_out (bit_out),
        .bit_vld (bit_vld),
        .act_cnt (act_cnt)
    );

    always #10 rx_clk = ~rx_clk;

    logic  a0d [NSTEP];
    logic  a0s [NSTEP];
    logic  a1d [NSTEP];
    logic  a1s [NSTEP];
    logic  en_at [NSTEP];
    int    k = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string ph = "R8";
    logic  mref = 1'b0;
    logic [2:0] mcnt = 3'd0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at step %0d", req, act, exp, k);
        end
    endtask

    // new bit flips exactly one line so that data^strobe toggles
    task automatic half(input bit newbit, input logic v);
        if (newbit) begin
            sin = v ^ ~(din ^ sin);
            din = v;
        end
    endtask

    task automatic check_edge();
        bit         act;
        logic       x0, x1, t0, t1, eb0, eb1;
        logic [1:0] ev;
        string      ht;
        act = (k >= 4);
        if (act) act = en_at[k-1] && en_at[k-2] && en_at[k-3] && en_at[k-4];
        ht = (ph == "R9") ? "R9" : "R8";
        if (!act) begin
            mref = 1'b0;
            mcnt = 3'd0;
            chk(bit_vld == 2'b00, ht, int'(bit_vld), 0);
            chk(act_cnt == 3'd0, ht, int'(act_cnt), 0);
        end else begin
            x0 = a0d[k-3] ^ a0s[k-3];
            x1 = a1d[k-3] ^ a1s[k-3];
            t0 = x0 ^ mref;
            t1 = x1 ^ x0;
            ev = {t0 & t1, t0 | t1};
            eb0 = t0 ? a0d[k-3] : a1d[k-3];
            eb1 = a1d[k-3];
            mref = x1;
            if (ev[0]) mcnt = mcnt + 3'd1;
            chk(bit_vld == ev, ph, int'(bit_vld), int'(ev));
            chk(bit_vld != 2'b10, "R3", int'(bit_vld), int'(ev));
            chk(act_cnt == mcnt, ev[0] ? "R6" : "R7", int'(act_cnt), int'(mcnt));
            if (ev[0]) chk(bit_out[0] == eb0, "R4", int'(bit_out[0]), int'(eb0));
            if (ev[1]) chk(bit_out[1] == eb1, "R4", int'(bit_out[1]), int'(eb1));
        end
    endtask

    task automatic step(input logic en_v, input bit n0, input logic v0,
                        input bit n1, input logic v1);
        @(posedge rx_clk);
        #5;
        if (k < NSTEP) begin
            check_edge();
            enable = en_v;
            en_at[k] = en_v;
            half(n0, v0);
            a0d[k] = din;
            a0s[k] = sin;
            #10;
            half(n1, v1);
            a1d[k] = din;
            a1s[k] = sin;
        end
        k++;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", k, NSTEP);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset state with enable low
        ph = "R8";
        for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 0, 1'b0);
        // R10: idle after enable, then isolated bits on each edge
        ph = "R10";
        for (int i = 0; i < 8; i++) step(1'b1, 0, 1'b0, 0, 1'b0);
        step(1'b1, 1, 1'b1, 0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 0, 1'b0, 0, 1'b0);
        step(1'b1, 0, 1'b0, 1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 0, 1'b0, 0, 1'b0);
        // R4: single bits alternating between first and second sample
        ph = "R4";
        for (int i = 0; i < 20; i++) begin
            if (i % 2 == 0) step(1'b1, 1, i[1], 0, 1'b0);
            else            step(1'b1, 0, 1'b0, 1, ~i[1]);
        end
        // R1: full rate, two bits on every cycle
        ph = "R1";
        for (int i = 0; i < 40; i++) step(1'b1, 1, 1'($urandom), 1, 1'($urandom));
        // R5: sparse traffic, reference carried across cycles
        ph = "R5";
        for (int i = 0; i < 30; i++) step(1'b1, ($urandom % 4) == 0, 1'($urandom), 0, 1'b0);
        // R2: random mix
        ph = "R2";
        for (int i = 0; i < 600; i++)
            step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        // R8: enable dropped while traffic continues
        ph = "R8";
        for (int i = 0; i < 10; i++) step(1'b0, 1, 1'($urandom), 1, 1'($urandom));
        // R9: enable raised with traffic present
        ph = "R9";
        for (int i = 0; i < 10; i++) step(1'b1, 1, 1'($urandom), 1, 1'($urandom));
        ph = "R2";
        for (int i = 0; i < 100; i++)
            step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b0, 0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule